// File: doc/BRIEF.md
# Integer ALU with Carry and Zero Flags

This block is the integer slice of a 32-bit execute stage. Each cycle in which `op_valid` is high it takes an opcode, two source register values, the current contents of the destination register, an immediate and the current two-bit flag register. One clock edge later it presents the result, a destination write strobe and the new flags. Arithmetic covers add, subtract, compare, increment and decrement, and it shares one adder. Single-bit left and right shifts push the bit that falls off into carry.

Two load forms rewrite one half of the destination from a 16-bit immediate and keep the other half. A third load writes a 24-bit stack pointer, but only when the immediate fits. An immediate that does not fit raises a range error and writes nothing. Opcodes with no defined meaning raise an illegal-operation strobe, write nothing and pass the incoming flags through unchanged. The surrounding pipeline owns the register file and the flag register. It uses `wr_en`, `sp_wr_en` and `flags_out` to commit the outcome.

Top module: `int_alu_core`

## Requirements
- R1: Opcode 0 (add) yields `src_a + src_b` with `wr_en` high. Flag bit 1 (carry) is the carry out of bit 31 of that sum.
- R2: Opcode 1 (subtract) yields `src_b - src_a` with `wr_en` high. Carry is the borrow, which is set exactly when `src_a > src_b` unsigned.
- R3: Opcode 2 (compare) sets the flags exactly as subtract would and keeps `wr_en` low. `result` still shows the difference.
- R4: Opcodes 3 (increment) and 4 (decrement) use `src_a` alone and add or subtract 1. Carry is set on wrap: increment of all ones, or decrement of zero.
- R5: Opcode 5 shifts `src_a` left by one and sets carry to the old bit 31. Opcode 6 shifts it right by one, fills with zero, and sets carry to the old bit 0.
- R6: For opcodes 0 to 6, flag bit 0 (zero) is set exactly when the 32-bit result is zero.
- R7: Opcode 7 replaces bits 15:0 of `dst_old` with `imm[15:0]` and keeps bits 31:16. Opcode 8 places `imm[15:0]` in bits 31:16 and keeps bits 15:0. Both raise `wr_en` and leave the flags equal to `flags_in`.
- R8: Opcode 9 with `imm[31:24]` all zero raises `sp_wr_en` with `sp_value = imm[23:0]` and leaves the flags unchanged.
- R9: Opcode 9 with any of `imm[31:24]` set raises `sp_err`, keeps `sp_wr_en` and `wr_en` low, and leaves the flags unchanged.
- R10: Opcodes 10 to 15 raise `illegal_op`, keep both write strobes low and return `flags_out = flags_in`.
- R11: Every output is registered with one cycle of latency. After reset all outputs are zero, and `res_valid` is high only in the cycle after an accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation select |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| dst_old | input | 32 | Current destination contents for half loads |
| imm | input | 32 | Immediate for the load forms |
| flags_in | input | 2 | Current flags: bit 0 zero, bit 1 carry |
| res_valid | output | 1 | Outputs below belong to an operation |
| result | output | 32 | Result value |
| wr_en | output | 1 | Write result into the destination register |
| flags_out | output | 2 | Updated flags |
| sp_wr_en | output | 1 | Write `sp_value` into the stack pointer |
| sp_value | output | 24 | New stack pointer |
| illegal_op | output | 1 | Opcode has no defined meaning |
| sp_err | output | 1 | Stack pointer immediate out of range |

## Verification
The sweep crosses every computing opcode with operand values at the sign boundary, at zero, at all ones and just around the 24-bit limit. That exposes carry wired from the wrong end of a shift, or borrow taken with its sense inverted. A design that swapped the subtract operands would fail every unequal pair. One that wrote on compare would raise `wr_en`, and one that dropped the kept half of a half load would corrupt the upper or lower 16 bits. Immediates just above 24 bits must be refused and 0x00FFFFFF must be accepted, which catches an off-by-one range test. The undefined opcodes are driven with each flag pattern to show the flags pass through untouched.

// File: rtl/int_alu_pkg.sv
`timescale 1ns/1ps
package int_alu_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_ADD  = 4'd0;
    localparam logic [OPC_W-1:0] OPC_SUB  = 4'd1;
    localparam logic [OPC_W-1:0] OPC_CMP  = 4'd2;
    localparam logic [OPC_W-1:0] OPC_INC  = 4'd3;
    localparam logic [OPC_W-1:0] OPC_DEC  = 4'd4;
    localparam logic [OPC_W-1:0] OPC_SHL  = 4'd5;
    localparam logic [OPC_W-1:0] OPC_SHR  = 4'd6;
    localparam logic [OPC_W-1:0] OPC_LDLO = 4'd7;
    localparam logic [OPC_W-1:0] OPC_LDHI = 4'd8;
    localparam logic [OPC_W-1:0] OPC_LDSP = 4'd9;

    localparam int FLAG_Z = 0;
    localparam int FLAG_C = 1;

    // adder personalities
    typedef enum logic [1:0] {
        AS_ADD = 2'd0,   // a + b
        AS_RSB = 2'd1,   // b - a
        AS_INC = 2'd2,   // a + 1
        AS_DEC = 2'd3    // a - 1
    } addsub_mode_e;

endpackage

// File: rtl/int_alu_addsub.sv
`timescale 1ns/1ps
module int_alu_addsub
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  addsub_mode_e      mode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] sum,
    output logic              carry
);
    localparam int EXT_W = DATA_W + 1;

    logic [DATA_W-1:0] x_op;
    logic [DATA_W-1:0] y_op;
    logic              cin;
    logic              is_borrow;
    logic [EXT_W-1:0]  wide;

    // one adder serves all four forms; borrow is the inverted carry out
    always_comb begin
        x_op      = src_a;
        y_op      = src_b;
        cin       = 1'b0;
        is_borrow = 1'b0;
        unique case (mode)
            AS_ADD: begin
                x_op = src_a;
                y_op = src_b;
            end
            AS_RSB: begin
                x_op      = src_b;
                y_op      = ~src_a;
                cin       = 1'b1;
                is_borrow = 1'b1;
            end
            AS_INC: begin
                y_op = '0;
                cin  = 1'b1;
            end
            AS_DEC: begin
                y_op      = '1;
                is_borrow = 1'b1;
            end
            default: ;
        endcase
    end

    assign wide  = {1'b0, x_op} + {1'b0, y_op} + {{DATA_W{1'b0}}, cin};
    assign sum   = wide[DATA_W-1:0];
    assign carry = wide[DATA_W] ^ is_borrow;

endmodule

// File: rtl/int_alu_shift1.sv
`timescale 1ns/1ps
module int_alu_shift1 #(
    parameter int DATA_W = 32
) (
    input  logic              go_left,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] shifted,
    output logic              spill
);
    always_comb begin
        if (go_left) begin
            shifted = {src[DATA_W-2:0], 1'b0};
            spill   = src[DATA_W-1];
        end else begin
            shifted = {1'b0, src[DATA_W-1:1]};
            spill   = src[0];
        end
    end
endmodule

// File: rtl/int_alu_ldimm.sv
`timescale 1ns/1ps
module int_alu_ldimm #(
    parameter int DATA_W = 32,
    parameter int SP_W   = 24
) (
    input  logic              upper,
    input  logic [DATA_W-1:0] dst_old,
    input  logic [DATA_W-1:0] imm,
    output logic [DATA_W-1:0] merged,
    output logic              sp_fits
);
    localparam int HALF_W = DATA_W / 2;

    assign merged = upper ? {imm[HALF_W-1:0], dst_old[HALF_W-1:0]}
                          : {dst_old[DATA_W-1:HALF_W], imm[HALF_W-1:0]};

    generate
        if (SP_W < DATA_W) begin : g_sp_narrow
            assign sp_fits = ~|imm[DATA_W-1:SP_W];
        end else begin : g_sp_full
            assign sp_fits = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/int_alu_core.sv
`timescale 1ns/1ps
module int_alu_core
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SP_W   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        opcode,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] dst_old,
    input  logic [DATA_W-1:0] imm,
    input  logic [1:0]        flags_in,
    output logic              res_valid,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic [1:0]        flags_out,
    output logic              sp_wr_en,
    output logic [SP_W-1:0]   sp_value,
    output logic              illegal_op,
    output logic              sp_err
);
    typedef struct packed {
        logic              res_valid;
        logic [DATA_W-1:0] result;
        logic              wr_en;
        logic [1:0]        flags;
        logic              sp_wr_en;
        logic [SP_W-1:0]   sp_value;
        logic              illegal;
        logic              sp_err;
    } alu_state_t;

    alu_state_t st_d, st_q;

    addsub_mode_e      as_mode;
    logic [DATA_W-1:0] as_sum;
    logic              as_carry;
    logic [DATA_W-1:0] sh_out;
    logic              sh_spill;
    logic [DATA_W-1:0] ld_merged;
    logic              ld_sp_fits;

    always_comb begin
        unique case (opcode)
            OPC_SUB, OPC_CMP: as_mode = AS_RSB;
            OPC_INC:          as_mode = AS_INC;
            OPC_DEC:          as_mode = AS_DEC;
            default:          as_mode = AS_ADD;
        endcase
    end

    int_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .mode  (as_mode),
        .src_a (src_a),
        .src_b (src_b),
        .sum   (as_sum),
        .carry (as_carry)
    );

    int_alu_shift1 #(.DATA_W(DATA_W)) u_shift (
        .go_left (opcode == OPC_SHL),
        .src     (src_a),
        .shifted (sh_out),
        .spill   (sh_spill)
    );

    int_alu_ldimm #(.DATA_W(DATA_W), .SP_W(SP_W)) u_ldimm (
        .upper   (opcode == OPC_LDHI),
        .dst_old (dst_old),
        .imm     (imm),
        .merged  (ld_merged),
        .sp_fits (ld_sp_fits)
    );

    always_comb begin
        st_d           = st_q;
        st_d.res_valid = 1'b0;
        st_d.wr_en     = 1'b0;
        st_d.sp_wr_en  = 1'b0;
        st_d.illegal   = 1'b0;
        st_d.sp_err    = 1'b0;
        if (op_valid) begin
            st_d.res_valid = 1'b1;
            st_d.flags     = flags_in;
            case (opcode)
                OPC_ADD, OPC_SUB, OPC_CMP, OPC_INC, OPC_DEC: begin
                    st_d.result        = as_sum;
                    st_d.wr_en         = (opcode != OPC_CMP);
                    st_d.flags[FLAG_C] = as_carry;
                    st_d.flags[FLAG_Z] = (as_sum == '0);
                end
                OPC_SHL, OPC_SHR: begin
                    st_d.result        = sh_out;
                    st_d.wr_en         = 1'b1;
                    st_d.flags[FLAG_C] = sh_spill;
                    st_d.flags[FLAG_Z] = (sh_out == '0);
                end
                OPC_LDLO, OPC_LDHI: begin
                    st_d.result = ld_merged;
                    st_d.wr_en  = 1'b1;
                end
                OPC_LDSP: begin
                    if (ld_sp_fits) begin
                        st_d.sp_wr_en = 1'b1;
                        st_d.sp_value = imm[SP_W-1:0];
                    end else begin
                        st_d.sp_err = 1'b1;
                    end
                end
                default: begin
                    st_d.illegal = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid  = st_q.res_valid;
    assign result     = st_q.result;
    assign wr_en      = st_q.wr_en;
    assign flags_out  = st_q.flags;
    assign sp_wr_en   = st_q.sp_wr_en;
    assign sp_value   = st_q.sp_value;
    assign illegal_op = st_q.illegal;
    assign sp_err     = st_q.sp_err;

endmodule

// File: rtl/int_alu_checker.sv
`timescale 1ns/1ps
module int_alu_checker
    import int_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SP_W   = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        opcode,
    input logic [DATA_W-1:0] dst_old,
    input logic [DATA_W-1:0] imm,
    input logic [1:0]        flags_in,
    input logic              res_valid,
    input logic [DATA_W-1:0] result,
    input logic              wr_en,
    input logic [1:0]        flags_out,
    input logic              sp_wr_en,
    input logic [SP_W-1:0]   sp_value,
    input logic              illegal_op,
    input logic              sp_err
);
    localparam int HALF_W = DATA_W / 2;

    p_cmp_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OPC_CMP) |=> (res_valid && !wr_en));

    p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode <= OPC_SHR) |=> (flags_out[FLAG_Z] == (result == '0)));

    p_lo_keeps_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OPC_LDLO) |=>
            (wr_en && result[DATA_W-1:HALF_W] == $past(dst_old[DATA_W-1:HALF_W])
             && flags_out == $past(flags_in)));

    p_hi_keeps_lower_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OPC_LDHI) |=>
            (wr_en && result[HALF_W-1:0] == $past(dst_old[HALF_W-1:0])));

    p_sp_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OPC_LDSP && imm[DATA_W-1:SP_W] == '0) |=>
            (sp_wr_en && sp_value == $past(imm[SP_W-1:0]) && flags_out == $past(flags_in)));

    p_sp_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OPC_LDSP && imm[DATA_W-1:SP_W] != '0) |=>
            (sp_err && !sp_wr_en && !wr_en));

    p_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode > OPC_LDSP) |=>
            (illegal_op && !wr_en && !sp_wr_en && flags_out == $past(flags_in)));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !wr_en && !sp_wr_en && !illegal_op && !sp_err));

    p_strobes_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, sp_wr_en, illegal_op, sp_err}));

endmodule

bind int_alu_core int_alu_checker #(.DATA_W(DATA_W), .SP_W(SP_W)) u_int_alu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .opcode     (opcode),
    .dst_old    (dst_old),
    .imm        (imm),
    .flags_in   (flags_in),
    .res_valid  (res_valid),
    .result     (result),
    .wr_en      (wr_en),
    .flags_out  (flags_out),
    .sp_wr_en   (sp_wr_en),
    .sp_value   (sp_value),
    .illegal_op (illegal_op),
    .sp_err     (sp_err)
);

// File: tb/tb_int_alu_core.sv
`timescale 1ns/1ps
module tb_int_alu_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic [31:0] src_a = '0, src_b = '0, dst_old = '0, imm = '0;
    logic [1:0]  flags_in = '0;
    logic        res_valid, wr_en, sp_wr_en, illegal_op, sp_err;
    logic [31:0] result;
    logic [1:0]  flags_out;
    logic [23:0] sp_value;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;   // 125 MHz

    int_alu_core dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .src_a(src_a), .src_b(src_b), .dst_old(dst_old), .imm(imm),
        .flags_in(flags_in), .res_valid(res_valid), .result(result),
        .wr_en(wr_en), .flags_out(flags_out), .sp_wr_en(sp_wr_en),
        .sp_value(sp_value), .illegal_op(illegal_op), .sp_err(sp_err)
    );

    logic [31:0] vals [8] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h8000_0000,
                              32'hFFFF_FFFF, 32'h00FF_FFFF, 32'h0100_0000, 32'hA5A5_C3C3};

    // expected outputs
    logic [31:0] e_res;
    logic        e_wr, e_spwr, e_ill, e_err, e_cmp_res;
    logic [1:0]  e_fl;
    logic [23:0] e_sp;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op, input logic bad);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3, 4'd4: return "R4";
            4'd5, 4'd6: return "R5";
            4'd7, 4'd8: return "R7";
            4'd9: return bad ? "R9" : "R8";
            default: return "R10";
        endcase
    endfunction

    // model built from the requirements
    task automatic model(input logic [3:0] op, input logic [31:0] a, b, d, im,
                         input logic [1:0] fl);
        logic [32:0] s;
        logic        c;
        e_res = '0; e_wr = 1'b0; e_spwr = 1'b0; e_ill = 1'b0; e_err = 1'b0;
        e_fl = fl; e_sp = '0; e_cmp_res = 1'b0; c = 1'b0;
        case (op)
            4'd0: begin s = {1'b0, a} + {1'b0, b}; e_res = s[31:0]; c = s[32]; end
            4'd1, 4'd2: begin e_res = b - a; c = (a > b); end
            4'd3: begin e_res = a + 32'd1; c = (a == 32'hFFFF_FFFF); end
            4'd4: begin e_res = a - 32'd1; c = (a == 32'd0); end
            4'd5: begin e_res = a << 1; c = a[31]; end
            4'd6: begin e_res = a >> 1; c = a[0]; end
            4'd7: e_res = {d[31:16], im[15:0]};
            4'd8: e_res = {im[15:0], d[15:0]};
            4'd9: if (im[31:24] == 8'd0) begin e_spwr = 1'b1; e_sp = im[23:0]; end
                  else e_err = 1'b1;
            default: e_ill = 1'b1;
        endcase
        if (op <= 4'd6) begin
            e_fl = {c, (e_res == 32'd0)};
            e_wr = (op != 4'd2);
            e_cmp_res = 1'b1;
        end
        if (op == 4'd7 || op == 4'd8) begin
            e_wr = 1'b1;
            e_cmp_res = 1'b1;
        end
    endtask

    task automatic run(input logic [3:0] op, input logic [31:0] a, b, d, im,
                       input logic [1:0] fl);
        string t;
        @(negedge clk);
        op_valid = 1'b1; opcode = op; src_a = a; src_b = b;
        dst_old = d; imm = im; flags_in = fl;
        model(op, a, b, d, im, fl);
        t = tag_of(op, im[31:24] != 8'd0);
        @(negedge clk);   // result registered at the edge in between
        op_valid = 1'b0;
        check("R11", "res_valid", {31'd0, res_valid}, 32'd1);
        if (e_cmp_res) check(t, "result", result, e_res);
        check(t, "wr_en", {31'd0, wr_en}, {31'd0, e_wr});
        check(t, "carry/flag1", {31'd0, flags_out[1]}, {31'd0, e_fl[1]});
        check((op <= 4'd6) ? "R6" : t, "zero/flag0", {31'd0, flags_out[0]}, {31'd0, e_fl[0]});
        check(t, "sp_wr_en", {31'd0, sp_wr_en}, {31'd0, e_spwr});
        if (e_spwr) check(t, "sp_value", {8'd0, sp_value}, {8'd0, e_sp});
        check(t, "sp_err", {31'd0, sp_err}, {31'd0, e_err});
        check(t, "illegal_op", {31'd0, illegal_op}, {31'd0, e_ill});
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_fail++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "reset res_valid", {31'd0, res_valid}, 32'd0);
        check("R11", "reset result", result, 32'd0);
        check("R11", "reset flags", {30'd0, flags_out}, 32'd0);
        check("R11", "reset strobes", {28'd0, wr_en, sp_wr_en, illegal_op, sp_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "idle res_valid", {31'd0, res_valid}, 32'd0);

        // R1..R6: arithmetic and shifts over all operand pairs
        for (int op = 0; op <= 6; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run(op[3:0], vals[i], vals[j], 32'h0, 32'h0, 2'((i + j + op) % 4));

        // R7..R9: loads over destination and immediate pairs
        for (int op = 7; op <= 9; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run(op[3:0], 32'h0, 32'h0, vals[i], vals[j], 2'((i * 3 + j) % 4));

        // R10: undefined opcodes with every flag pattern
        for (int op = 10; op <= 15; op++)
            for (int f = 0; f < 4; f++)
                run(op[3:0], vals[f], vals[f + 4], vals[f], vals[f], f[1:0]);

        // R11: one idle cycle after an operation drops res_valid
        @(negedge clk);
        check("R11", "res_valid after idle", {31'd0, res_valid}, 32'd0);
        check("R11", "wr_en after idle", {31'd0, wr_en}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule